// File: doc/BRIEF.md
# External Bus Cycle Length Controller

This block decides how long each external bus cycle lasts and produces the bus strobes that frame it. A CPU-side request (direction and 24-bit address) is latched into the controller, which raises a main strobe for a number of cycles. That number comes from a down-counter loaded with a programmable wait count, an external ready input, or a mix of the two chosen by a two-bit merge field. A bank-compare option adds one idle (null) cycle in front of a read whose bank differs from the bank of the previous access. Four page strobes, one per quarter of the address space, follow the main strobe.

A write is posted: the controller takes it in the cycle it is offered while the bus is free, so the CPU carries on at once. A later access offered while that write is still on the bus sees `stall` until the bus is free again. A one-cycle `done` pulse marks the end of every bus cycle. Settings come from a small control register inside the block, loaded through `ctl_we`/`ctl_wdata`.

The state machine has three states. In `ST_IDLE` the bus is free. `ST_NULL` is the inserted dead cycle. `ST_XFER` is the strobed transfer. The transitions are:
- idle-to-xfer: a request is taken and no null cycle is needed.
- idle-to-null: a read is taken, bank compare is on, and the bank differs.
- null-to-xfer: this always happens after the single dead cycle.
- xfer-to-idle: the merged ready is high at a rising edge.
- xfer-hold: the merged ready is low.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: After reset, the control register holds wait count 7, merge mode 11 (either) and bank compare off, and all outputs are low. With `ext_rdy` held low, an access keeps `bus_stb` high for 8 cycles.
- R2: Merge mode 00 ends the strobe at the first rising edge where `ext_rdy` is high, whatever the counter holds. If `ext_rdy` is high in strobe cycle k (counting from 0), the strobe lasts k+1 cycles.
- R3: Merge mode 01 ignores `ext_rdy` and holds the strobe for wait count + 1 cycles.
- R4: Merge mode 10 ends the strobe only when the counter has expired and `ext_rdy` is high together, giving max(W, k)+1 cycles.
- R5: Merge mode 11 ends the strobe when either the counter has expired or `ext_rdy` is high, giving min(W, k)+1 cycles.
- R6: With bank compare on, a read whose address bits [23:16] differ from those of the previous access sees exactly one cycle with `bus_stb` low between acceptance and strobe. A read in the same bank sees none.
- R7: A write never gets a null cycle, even with bank compare on and a bank change.
- R8: `page_stb[k]` is high exactly when `bus_stb` is high and address bits [23:22] equal k. Otherwise all page strobes are low.
- R9: A request offered while the controller is idle is taken with `stall` low in that same cycle. A request offered during a transfer sees `stall` high until the cycle after the last strobe cycle.
- R10: `done` is high for exactly one cycle, the cycle right after the last strobe cycle.
- R11: The remembered bank resets to 0, so the first read after reset to bank 0 gets no null cycle.
- R12: A cycle with `ctl_we` high loads the control register with this layout: `ctl_wdata[2:0]` is the wait count, `[4:3]` is the merge mode, and `[5]` is the bank-compare enable. The new value governs accesses taken afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; ready is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Load strobe for the control register |
| ctl_wdata | input | 6 | Control value: bank enable, merge mode, wait count |
| req | input | 1 | CPU access request, held until taken |
| req_wr | input | 1 | Request direction, 1 = write |
| req_addr | input | 24 | Request address |
| ext_rdy | input | 1 | External ready, active high |
| bus_stb | output | 1 | Main bus strobe for the transfer |
| bus_wr | output | 1 | Direction of the access on the bus |
| bus_addr | output | 24 | Address of the access on the bus |
| page_stb | output | 4 | Quarter-space page strobes |
| done | output | 1 | One-cycle end-of-transfer pulse |
| stall | output | 1 | Request cannot be taken this cycle |

## Verification
The end of a posted write and the acceptance of the next access can fall in the same cycle. `done` for the write is high in exactly the cycle where `stall` drops for the waiting request, and the bank decision for that request must see the write's bank. The bench provokes this by offering a read right behind a write and holding it through the write's strobe. It counts the stall cycles, checks that `done` is high when stall first drops, and runs a bank-change read right after a write. A behavioural per-cycle model judges strobe, page strobes, `done` and `stall` on every clock. Directed checks compare each merge mode's strobe length against a count computed from the mode formula.

// File: rtl/xbw_pkg.sv
package xbw_pkg;
    localparam int XBW_WAIT_W = 3;
    localparam int XBW_CTL_W  = XBW_WAIT_W + 3;

    typedef enum logic [1:0] {
        MRG_EXT_ONLY = 2'b00,
        MRG_CNT_ONLY = 2'b01,
        MRG_BOTH     = 2'b10,
        MRG_EITHER   = 2'b11
    } merge_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_NULL = 2'd1,
        ST_XFER = 2'd2
    } bus_st_e;

    typedef struct packed {
        logic                  bank_chk;
        merge_e                merge;
        logic [XBW_WAIT_W-1:0] waits;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{bank_chk: 1'b0, merge: MRG_EITHER, waits: '1};
endpackage

// File: rtl/xbw_ctl_reg.sv
module xbw_ctl_reg
    import xbw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [XBW_CTL_W-1:0] wdata,
    output ctl_t                 ctl
);
    ctl_t ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (we) begin
            ctl_q <= ctl_t'(wdata);
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/xbw_wait_merge.sv
module xbw_wait_merge
    import xbw_pkg::*;
#(
    parameter int WAIT_W = XBW_WAIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [WAIT_W-1:0] load_val,
    input  merge_e            merge,
    input  logic              ext_rdy,
    output logic              rdy
);
    logic [WAIT_W-1:0] cnt_q;
    logic              expired;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (active && !expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        unique case (merge)
            MRG_EXT_ONLY: rdy = ext_rdy;
            MRG_CNT_ONLY: rdy = expired;
            MRG_BOTH:     rdy = expired && ext_rdy;
            MRG_EITHER:   rdy = expired || ext_rdy;
            default:      rdy = expired;
        endcase
    end

    // R3
    cnt_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/xbw_bank_track.sv
module xbw_bank_track #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BANK_W-1:0] bank_in,
    output logic              miss
);
    logic [BANK_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (capture) begin
            last_q <= bank_in;
        end
    end

    assign miss = (bank_in != last_q);

    // R11
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(last_q));
endmodule

// File: rtl/xbw_page_dec.sv
module xbw_page_dec #(
    parameter int PAGES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     stb,
    input  logic [$clog2(PAGES)-1:0] sel,
    output logic [PAGES-1:0]         page_stb
);
    localparam int SEL_W = $clog2(PAGES);

    for (genvar k = 0; k < PAGES; k++) begin : g_page
        assign page_stb[k] = stb && (sel == SEL_W'(k));
    end

    // R8
    page_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> ($countones(page_stb) == 1));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
    import xbw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BANK_W = 8,
    parameter int PAGES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic [XBW_CTL_W-1:0] ctl_wdata,
    input  logic                 req,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 ext_rdy,
    output logic                 bus_stb,
    output logic                 bus_wr,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [PAGES-1:0]     page_stb,
    output logic                 done,
    output logic                 stall
);
    localparam int SEL_W = $clog2(PAGES);

    bus_st_e           state, nxt;
    ctl_t              ctl;
    logic              take;
    logic              bank_miss;
    logic              rdy;
    logic              done_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;

    xbw_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    xbw_wait_merge #(.WAIT_W(XBW_WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take),
        .active   (state == ST_XFER),
        .load_val (ctl.waits),
        .merge    (ctl.merge),
        .ext_rdy  (ext_rdy),
        .rdy      (rdy)
    );

    xbw_bank_track #(.BANK_W(BANK_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (take),
        .bank_in (req_addr[ADDR_W-1 -: BANK_W]),
        .miss    (bank_miss)
    );

    xbw_page_dec #(.PAGES(PAGES)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bus_stb),
        .sel      (addr_q[ADDR_W-1 -: SEL_W]),
        .page_stb (page_stb)
    );

    assign take = req && (state == ST_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            state  <= nxt;
            done_q <= (state == ST_XFER) && rdy;
            if (take) begin
                wr_q   <= req_wr;
                addr_q <= req_addr;
            end
        end
    end

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!req_wr && ctl.bank_chk && bank_miss) nxt = ST_NULL;
                    else                                      nxt = ST_XFER;
                end
            end
            ST_NULL: nxt = ST_XFER;
            ST_XFER: if (rdy) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_stb  = (state == ST_XFER);
        bus_wr   = wr_q;
        bus_addr = addr_q;
        done     = done_q;
        stall    = req && (state != ST_IDLE);
    end

    // R7
    null_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NULL) |-> !wr_q);

    // R6
    null_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NULL) |=> (state == ST_XFER));

    // R10
    done_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(bus_stb) && !bus_stb));

    // R9
    write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_wr && !stall) |=> (state != ST_IDLE));
endmodule

// File: tb/sim_xbus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_wait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [5:0]  ctl_wdata = '0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [23:0] req_addr = '0;
    logic        ext_rdy = 1'b0;
    logic        bus_stb, bus_wr, done, stall;
    logic [23:0] bus_addr;
    logic [3:0]  page_stb;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbus_wait_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .req(req), .req_wr(req_wr), .req_addr(req_addr), .ext_rdy(ext_rdy),
        .bus_stb(bus_stb), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .page_stb(page_stb), .done(done), .stall(stall)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_st, m_cnt, m_last, m_addr, c_w, c_m;
    bit m_done, m_wr, c_b;
    always @(posedge clk) begin
        int nb;
        bit ex, r;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_last = 0; m_addr = 0; m_done = 0; m_wr = 0;
            c_w = 7; c_m = 3; c_b = 0;
        end else begin
            m_done = 0;
            if (m_st == 0) begin
                if (req) begin
                    nb = int'(req_addr[23:16]);
                    m_addr = int'(req_addr);
                    m_wr = req_wr;
                    m_cnt = c_w;
                    m_st = (!req_wr && c_b && nb != m_last) ? 1 : 2;
                    m_last = nb;
                end
            end else if (m_st == 1) begin
                m_st = 2;
            end else begin
                ex = (m_cnt == 0);
                if (c_m == 0)      r = ext_rdy;
                else if (c_m == 1) r = ex;
                else if (c_m == 2) r = ex && ext_rdy;
                else               r = ex || ext_rdy;
                if (r) begin m_st = 0; m_done = 1; end
                else if (m_cnt > 0) m_cnt--;
            end
            if (ctl_we) begin
                c_w = int'(ctl_wdata[2:0]);
                c_m = int'(ctl_wdata[4:3]);
                c_b = ctl_wdata[5];
            end
        end
    end

    // Per-clock comparison, mid-cycle after inputs have settled
    always @(posedge clk) begin
        #15;
        if (rst_n && !finished) begin
            chk("R5", int'(bus_stb), int'(m_st == 2), "strobe vs model");
            chk("R8", int'(page_stb), (m_st == 2) ? (1 << (m_addr >> 22)) : 0, "pages vs model");
            chk("R9", int'(stall), int'(req && m_st != 0), "stall vs model");
            chk("R10", int'(done), int'(m_done), "done vs model");
            if (m_st == 2) begin
                chk("R5", int'(bus_wr), int'(m_wr), "direction vs model");
                chk("R5", int'(bus_addr), m_addr, "address vs model");
            end
        end
    end

    function automatic int ref_len(input int mode, input int w, input int ra);
        int lo, hi;
        lo = (w < ra) ? w : ra;
        hi = (w > ra) ? w : ra;
        case (mode)
            0:       return ra + 1;
            1:       return w + 1;
            2:       return hi + 1;
            default: return (ra < 0) ? w + 1 : lo + 1;
        endcase
    endfunction

    task automatic set_ctl(input bit b, input int m, input int w);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = {b, 2'(m), 3'(w)};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = 1'b0;
        ext_rdy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One access; ext_rdy rises in strobe cycle ra (never when ra < 0)
    task automatic do_acc(input bit wr, input logic [23:0] a, input int ra,
                          input int exp_len, input int exp_gap,
                          input string len_tag, input string gap_tag);
        int len = 0;
        int gap = 0;
        bit seen = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; ext_rdy = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            req = 1'b0;
            if (done) begin
                seen = 1'b1;
            end else if (bus_stb) begin
                len++;
                chk("R8", int'(page_stb), 1 << a[23:22], "page strobe");
                ext_rdy = (ra >= 0) && (len - 1 >= ra);
            end else if (len == 0) begin
                gap++;
            end
        end
        ext_rdy = 1'b0;
        chk(len_tag, len, exp_len, "strobe length");
        chk(gap_tag, gap, exp_gap, "null cycles");
        chk("R10", int'(seen), 1, "done seen");
        @(negedge clk);
        chk("R10", int'(done), 0, "done one cycle");
    endtask

    initial begin
        int n;
        do_reset();
        @(negedge clk);
        chk("R1", int'(bus_stb), 0, "reset strobe");
        chk("R1", int'(page_stb), 0, "reset pages");
        chk("R1", int'(done), 0, "reset done");
        chk("R1", int'(stall), 0, "reset stall");

        // R1 defaults: seven waits, either-merge
        do_acc(1'b0, 24'h123456, -1, ref_len(3, 7, -1), 0, "R1", "R1");
        do_acc(1'b0, 24'h400000, 2, ref_len(3, 7, 2), 0, "R1", "R1");

        // R2 external only, R12 field load
        set_ctl(1'b0, 0, 7);
        do_acc(1'b0, 24'h800000, 2, ref_len(0, 7, 2), 0, "R2", "R2");
        do_acc(1'b1, 24'hC00010, 0, ref_len(0, 7, 0), 0, "R2", "R2");

        // R3 counter only
        set_ctl(1'b0, 1, 3);
        do_acc(1'b0, 24'h7FFFFF, 0, ref_len(1, 3, 0), 0, "R3", "R3");
        do_acc(1'b0, 24'hBFFFFF, -1, ref_len(1, 3, -1), 0, "R3", "R3");

        // R4 both required
        set_ctl(1'b0, 2, 2);
        do_acc(1'b0, 24'h3F0000, 4, ref_len(2, 2, 4), 0, "R4", "R4");
        do_acc(1'b1, 24'hC80000, 0, ref_len(2, 2, 0), 0, "R4", "R4");

        // R5 either suffices
        set_ctl(1'b0, 3, 5);
        do_acc(1'b0, 24'h900000, 1, ref_len(3, 5, 1), 0, "R5", "R5");
        do_acc(1'b0, 24'hE00000, -1, ref_len(3, 5, -1), 0, "R5", "R5");
        do_acc(1'b1, 24'h500000, 7, ref_len(3, 5, 7), 0, "R5", "R5");

        // R9 posted write followed by a read held behind it
        set_ctl(1'b0, 1, 3);
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 24'hC01000;
        #1 chk("R9", int'(stall), 0, "write taken at once");
        @(negedge clk);
        req_wr = 1'b0; req_addr = 24'h000010;
        #1;
        n = 0;
        while (stall && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
        chk("R9", n, 4, "stall cycles behind write");
        chk("R10", int'(done), 1, "write done as stall drops");
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            n++;
            @(negedge clk);
        end
        chk("R9", n, 4, "queued read completes");

        // R11, R6, R7 bank compare from a fresh reset
        do_reset();
        set_ctl(1'b1, 1, 0);
        do_acc(1'b0, 24'h001234, -1, 1, 0, "R12", "R11");
        do_acc(1'b0, 24'h130000, -1, 1, 1, "R12", "R6");
        do_acc(1'b0, 24'h13FFFF, -1, 1, 0, "R12", "R6");
        do_acc(1'b1, 24'h550000, -1, 1, 0, "R12", "R7");
        do_acc(1'b0, 24'h550004, -1, 1, 0, "R12", "R6");
        do_acc(1'b1, 24'h990000, -1, 1, 0, "R12", "R7");
        do_acc(1'b0, 24'hFF0000, -1, 1, 1, "R12", "R6");

        // R12 bank compare switched off again
        set_ctl(1'b0, 1, 0);
        do_acc(1'b0, 24'h220000, -1, 1, 0, "R12", "R12");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule